// File: doc/BRIEF.md
# Biphase-Mark Digital Audio Transmitter

This block serialises one stereo PCM stream into the two-channel consumer/professional digital audio line format. Each frame carries a left and a right subframe of 32 slots. A subframe holds a 4-slot sync preamble, 24 audio slots, then a validity, a user, a channel-status and a parity slot. Frames are counted in blocks of 192. The slots are biphase-mark coded onto a single line. The block runs on a clock at 128 times the sample rate, so every clock cycle produces one half-cell on the line.

All per-frame inputs are captured once, on the clock edge that starts the left subframe. These inputs are the selected stereo pair, the resolution, validity, user bit, force-zero control, rate selection and the 80-bit channel-status bank. A frame therefore never mixes old and new settings. Eight stereo sources are presented in parallel, and a 3-bit source register picks one of them. The channel-status bank comes from ten programmable bytes. The block substitutes a fixed four-bit sample-rate code into it, and uses its bit 1, the non-audio bit, to decide whether validity-driven muting applies.

Top module: `spdif_tx`

## Requirements
- R1: While `en_i` is low the line is driven low one edge later and frame/half-cell counting restarts, so the first half-cell after `en_i` rises begins a B preamble in frame 0.
- R2: In slots 4 to 31 the line toggles at the start of every slot and toggles again at mid-slot when the slot bit is 1; one half-cell is emitted per clock.
- R3: Slots 0 to 3 carry an 8-half-cell preamble: B = 11101000 in frame 0 of each 192-frame block, M = 11100010 for other left subframes, W = 11100100 for right subframes. Each is inverted when the line was high before it.
- R4: Slots 4 to 27 carry the 24-bit sample LSB first (sample bit k in slot 4+k). With `res24_i` low, sample bits 7:0 are sent as zero.
- R5: Slot 28 carries `valid_i` and slot 29 carries `user_i`, both captured at frame start and used for both subframes.
- R6: Slot 31 makes the count of ones in slots 4 to 31 even, so the line is low after every subframe.
- R7: Slot 30 of both subframes of frame f carries channel-status bit f for f < 80, where bit 8n+k is bit k of byte n of `cs_i`. For f >= 80 it carries 0.
- R8: Channel-status bits 24 to 27 are replaced by a rate code c, bit k of c going to bit 24+k. The code follows `rate_i`: 0 gives 0000 (44.1 kHz), 1 gives 0010 (48 kHz), 2 gives 0011 (32 kHz), 3 gives 1000 (88.2 kHz), 4 gives 1010 (96 kHz), and 5 to 7 give 0001 (rate not indicated).
- R9: When `force_zero_i` is high, `valid_i` is high and `cs_i` bit 1 is 0 at frame start, all 24 audio slots of that frame are zero. When `cs_i` bit 1 is 1, the audio is sent unchanged.
- R10: The source register resets to 3'b010 and loads `sel_i` on `sel_wr_i`. A value s selects the pair at bits s*24 upward of `src_l_i` and `src_r_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Half-cell clock, 128 x sample rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Transmitter enable |
| force_zero_i | input | 1 | Zero PCM audio of frames marked invalid |
| res24_i | input | 1 | 1: 24-bit samples, 0: 16-bit samples |
| sel_wr_i | input | 1 | Load strobe for the source register |
| sel_i | input | 3 | Source index to load |
| src_l_i | input | 192 | Eight left samples, 24 bits each |
| src_r_i | input | 192 | Eight right samples, 24 bits each |
| valid_i | input | 1 | Validity bit for the frame |
| user_i | input | 1 | User-data bit for the frame |
| rate_i | input | 3 | Sample-rate selection for the status code |
| cs_i | input | 80 | Ten channel-status bytes, byte n at bits 8n+7:8n |
| line_o | output | 1 | Biphase-mark coded line |

## Verification
The bench builds the block with its default parameters: eight 24-bit sources, ten status bytes and a 192-frame block. These values are small enough to run every frame of complete blocks, so each status bit, the frame-0 preamble and the block wrap can be compared half-cell by half-cell against a reference encoder written in the bench. With only eight sources and eight rate selections, the bench sweeps all of them, runs both resolutions, and exercises force-zero with the non-audio bit clear and set.

// File: rtl/spdif_tx_pkg.sv
package spdif_tx_pkg;
  typedef enum logic [1:0] {PRE_B, PRE_M, PRE_W} pre_e;

  localparam int SLOT_AUD = 4;
  localparam int SLOT_V   = 28;
  localparam int SLOT_U   = 29;
  localparam int SLOT_C   = 30;
  localparam int SLOT_P   = 31;
  localparam int RATE_LSB = 24;

  // half-cells in send order, msb first, for a low line before the preamble
  function automatic logic [7:0] pre_pattern(pre_e p);
    case (p)
      PRE_B:   return 8'b1110_1000;
      PRE_M:   return 8'b1110_0010;
      default: return 8'b1110_0100;
    endcase
  endfunction

  function automatic logic [3:0] rate_code(logic [2:0] r);
    case (r)
      3'd0:    return 4'b0000;
      3'd1:    return 4'b0010;
      3'd2:    return 4'b0011;
      3'd3:    return 4'b1000;
      3'd4:    return 4'b1010;
      default: return 4'b0001;
    endcase
  endfunction
endpackage

// File: rtl/spdif_tx_timer.sv
module spdif_tx_timer #(
  parameter int FRAMES = 192,
  parameter int SUB_HC = 64,
  localparam int HC_W = $clog2(SUB_HC),
  localparam int FR_W = $clog2(FRAMES)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  output logic [HC_W-1:0] hc_o,
  output logic            chan_o,
  output logic [FR_W-1:0] frame_o,
  output logic            frame_start_o
);
  logic [HC_W-1:0] hc_q;
  logic            chan_q;
  logic [FR_W-1:0] frame_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hc_q    <= '0;
      chan_q  <= 1'b0;
      frame_q <= '0;
    end else if (!en_i) begin
      hc_q    <= '0;
      chan_q  <= 1'b0;
      frame_q <= '0;
    end else begin
      hc_q <= hc_q + 1'b1;
      if (hc_q == HC_W'(SUB_HC - 1)) begin
        chan_q <= ~chan_q;
        if (chan_q)
          frame_q <= (frame_q == FR_W'(FRAMES - 1)) ? '0 : frame_q + 1'b1;
      end
    end
  end

  assign hc_o          = hc_q;
  assign chan_o        = chan_q;
  assign frame_o       = frame_q;
  assign frame_start_o = en_i && (hc_q == '0) && !chan_q;

  // R3
  frame_in_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(frame_q) < FRAMES);
endmodule

// File: rtl/spdif_tx_status.sv
module spdif_tx_status #(
  parameter int CS_BYTES = 10,
  parameter int FR_W     = 8,
  localparam int NCS     = CS_BYTES * 8
) (
  input  logic [NCS-1:0]  cs_i,
  input  logic [2:0]      rate_i,
  input  logic [FR_W-1:0] frame_i,
  output logic            cs_bit_o,
  output logic            non_audio_o
);
  import spdif_tx_pkg::*;

  localparam logic [NCS-1:0] RATE_MASK = NCS'(4'hF) << RATE_LSB;

  logic [NCS-1:0] cs_eff;

  assign cs_eff      = (cs_i & ~RATE_MASK) | (NCS'(rate_code(rate_i)) << RATE_LSB);
  assign cs_bit_o    = (int'(frame_i) < NCS) ? cs_eff[int'(frame_i) % NCS] : 1'b0;
  assign non_audio_o = cs_i[1];
endmodule

// File: rtl/spdif_tx_framer.sv
module spdif_tx_framer #(
  parameter int WORD_W = 24,
  parameter int SEL_W  = 3,
  localparam int NUM_SRC = 1 << SEL_W
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      frame_start_i,
  input  logic                      sel_wr_i,
  input  logic [SEL_W-1:0]          sel_i,
  input  logic [NUM_SRC*WORD_W-1:0] src_l_i,
  input  logic [NUM_SRC*WORD_W-1:0] src_r_i,
  input  logic                      res24_i,
  input  logic                      force_zero_i,
  input  logic                      valid_i,
  input  logic                      user_i,
  input  logic                      cs_bit_i,
  input  logic                      non_audio_i,
  input  logic                      chan_i,
  input  logic [4:0]                slot_i,
  output logic                      bit_o
);
  import spdif_tx_pkg::*;

  localparam logic [SEL_W-1:0] SEL_RST = SEL_W'(2);

  logic [WORD_W-1:0] l_arr [NUM_SRC];
  logic [WORD_W-1:0] r_arr [NUM_SRC];

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign l_arr[g] = src_l_i[g*WORD_W +: WORD_W];
    assign r_arr[g] = src_r_i[g*WORD_W +: WORD_W];
  end

  logic [SEL_W-1:0]  sel_q;
  logic [WORD_W-1:0] l_q, r_q, res_mask, word;
  logic              v_q, u_q, c_q, mute, par;

  assign res_mask = res24_i ? '1 : {{(WORD_W-8){1'b1}}, 8'h00};
  assign mute     = force_zero_i && valid_i && !non_audio_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= SEL_RST;
      l_q   <= '0;
      r_q   <= '0;
      v_q   <= 1'b0;
      u_q   <= 1'b0;
      c_q   <= 1'b0;
    end else begin
      if (sel_wr_i) sel_q <= sel_i;
      if (frame_start_i) begin
        l_q <= mute ? '0 : (l_arr[sel_q] & res_mask);
        r_q <= mute ? '0 : (r_arr[sel_q] & res_mask);
        v_q <= valid_i;
        u_q <= user_i;
        c_q <= cs_bit_i;
      end
    end
  end

  assign word = chan_i ? r_q : l_q;
  assign par  = ^{word, v_q, u_q, c_q};

  always_comb begin
    bit_o = 1'b0;
    if (int'(slot_i) >= SLOT_AUD && int'(slot_i) < SLOT_V)
      bit_o = word[int'(slot_i) - SLOT_AUD];
    else if (int'(slot_i) == SLOT_V) bit_o = v_q;
    else if (int'(slot_i) == SLOT_U) bit_o = u_q;
    else if (int'(slot_i) == SLOT_C) bit_o = c_q;
    else if (int'(slot_i) == SLOT_P) bit_o = par;
  end
endmodule

// File: rtl/spdif_tx_bmc.sv
module spdif_tx_bmc #(
  parameter int HC_W = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [HC_W-1:0]    hc_i,
  input  spdif_tx_pkg::pre_e pre_i,
  input  logic               bit_i,
  output logic               line_o
);
  import spdif_tx_pkg::*;

  localparam logic [HC_W-1:0] HC_LAST = '1;

  logic       line_q, inv_q, inv_eff, line_d;
  logic [7:0] pat;

  assign pat     = pre_pattern(pre_i);
  assign inv_eff = (hc_i == '0) ? line_q : inv_q;

  always_comb begin
    if (int'(hc_i) < 2 * SLOT_AUD) line_d = pat[3'd7 - hc_i[2:0]] ^ inv_eff;
    else if (!hc_i[0])             line_d = ~line_q;
    else                           line_d = line_q ^ bit_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= 1'b0;
      inv_q  <= 1'b0;
    end else if (!en_i) begin
      line_q <= 1'b0;
      inv_q  <= 1'b0;
    end else begin
      line_q <= line_d;
      if (hc_i == '0) inv_q <= line_q;
    end
  end

  assign line_o = line_q;

  // R1
  idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(en_i) |-> !line_o);
  // R2
  cell_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(en_i) && int'($past(hc_i)) >= 2 * SLOT_AUD && !$past(hc_i[0]))
      |-> (line_o != $past(line_o)));
  // R6
  even_subframe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(en_i) && $past(hc_i) == HC_LAST) |-> !line_o);
endmodule

// File: rtl/spdif_tx.sv
module spdif_tx #(
  parameter int WORD_W   = 24,
  parameter int SEL_W    = 3,
  parameter int CS_BYTES = 10,
  parameter int FRAMES   = 192,
  localparam int NUM_SRC = 1 << SEL_W,
  localparam int NCS     = CS_BYTES * 8,
  localparam int SUB_HC  = 64,
  localparam int HC_W    = $clog2(SUB_HC),
  localparam int FR_W    = $clog2(FRAMES)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      en_i,
  input  logic                      force_zero_i,
  input  logic                      res24_i,
  input  logic                      sel_wr_i,
  input  logic [SEL_W-1:0]          sel_i,
  input  logic [NUM_SRC*WORD_W-1:0] src_l_i,
  input  logic [NUM_SRC*WORD_W-1:0] src_r_i,
  input  logic                      valid_i,
  input  logic                      user_i,
  input  logic [2:0]                rate_i,
  input  logic [NCS-1:0]            cs_i,
  output logic                      line_o
);
  import spdif_tx_pkg::*;

  logic [HC_W-1:0] hc;
  logic            chan, frame_start, cs_bit, non_audio, slot_bit;
  logic [FR_W-1:0] frame;
  pre_e            pre;

  spdif_tx_timer #(.FRAMES(FRAMES), .SUB_HC(SUB_HC)) u_timer (
    .clk_i, .rst_ni, .en_i,
    .hc_o(hc), .chan_o(chan), .frame_o(frame), .frame_start_o(frame_start)
  );

  spdif_tx_status #(.CS_BYTES(CS_BYTES), .FR_W(FR_W)) u_status (
    .cs_i, .rate_i, .frame_i(frame), .cs_bit_o(cs_bit), .non_audio_o(non_audio)
  );

  spdif_tx_framer #(.WORD_W(WORD_W), .SEL_W(SEL_W)) u_framer (
    .clk_i, .rst_ni, .frame_start_i(frame_start), .sel_wr_i, .sel_i,
    .src_l_i, .src_r_i, .res24_i, .force_zero_i, .valid_i, .user_i,
    .cs_bit_i(cs_bit), .non_audio_i(non_audio), .chan_i(chan),
    .slot_i(hc[HC_W-1:1]), .bit_o(slot_bit)
  );

  assign pre = chan ? PRE_W : ((frame == '0) ? PRE_B : PRE_M);

  spdif_tx_bmc #(.HC_W(HC_W)) u_bmc (
    .clk_i, .rst_ni, .en_i, .hc_i(hc), .pre_i(pre), .bit_i(slot_bit), .line_o
  );
endmodule

// File: tb/spdif_tx_test.sv
module spdif_tx_test;
  localparam int W = 24, NS = 8, NB = 10, NCS = 80, NF = 192;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, en = 1'b0, force_zero = 1'b0, res24 = 1'b1;
  logic sel_wr = 1'b0, valid = 1'b0, user = 1'b0;
  logic [2:0] sel = '0, rate = '0;
  logic [W-1:0] src_l [NS];
  logic [W-1:0] src_r [NS];
  logic [7:0] cs_b [NB];
  logic [NS*W-1:0] src_l_v, src_r_v;
  logic [NCS-1:0] cs_v;
  logic line;

  always_comb begin
    for (int s = 0; s < NS; s++) begin
      src_l_v[s*W +: W] = src_l[s];
      src_r_v[s*W +: W] = src_r[s];
    end
    for (int b = 0; b < NB; b++) cs_v[b*8 +: 8] = cs_b[b];
  end

  spdif_tx uut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .force_zero_i(force_zero),
    .res24_i(res24), .sel_wr_i(sel_wr), .sel_i(sel), .src_l_i(src_l_v),
    .src_r_i(src_r_v), .valid_i(valid), .user_i(user), .rate_i(rate),
    .cs_i(cs_v), .line_o(line)
  );

  int vectors = 0, miscompares = 0;
  int m_h = 0, m_f = 0, seed = 0, vmode = 0;
  bit m_lvl = 0, m_inv = 0;
  logic [31:0] m_sub [2];
  int m_sel = 2;

  function automatic logic [3:0] exp_code(int r);
    case (r)
      0: return 4'h0; 1: return 4'h2; 2: return 4'h3;
      3: return 4'h8; 4: return 4'hA; default: return 4'h1;
    endcase
  endfunction

  task automatic build_frame();
    logic csb;
    int n;
    logic [W-1:0] w;
    n = m_f;
    if (n >= NCS) csb = 0;
    else if (n >= 24 && n < 28) csb = exp_code(int'(rate))[n-24];
    else csb = cs_b[n/8][n%8];
    for (int ch = 0; ch < 2; ch++) begin
      w = ch ? src_r[m_sel] : src_l[m_sel];
      if (!res24) w = w & 24'hFFFF00;
      if (force_zero && valid && !cs_b[0][1]) w = '0;
      m_sub[ch] = {1'b0, csb, user, valid, w, 4'h0};
      m_sub[ch][31] = ^m_sub[ch][30:4];
    end
  endtask

  task automatic set_frame_inputs();
    for (int s = 0; s < NS; s++) begin
      src_l[s] = W'((m_f + 1) * 40503 + s * 9973 + seed * 77) ^ W'(s << 20);
      src_r[s] = W'((m_f + 3) * 52711 + s * 7919 + seed * 31) ^ 24'h5A0000;
    end
    valid = (vmode == 0) ? 1'b0 : ((m_f % 3) != 1);
    user  = (m_f % 5) == 1;
  endtask

  task automatic cycle();
    logic e;
    string tag;
    int ch, hh, sl;
    logic [7:0] pat;
    if (en && m_h == 0) set_frame_inputs();
    @(posedge clk);
    tag = "R1";
    if (!en) begin
      e = 0; m_h = 0; m_f = 0; m_lvl = 0;
    end else begin
      if (m_h == 0) build_frame();
      ch = m_h / 64; hh = m_h % 64; sl = hh / 2;
      if (hh == 0) m_inv = m_lvl;
      if (sl < 4) begin
        pat = ch ? 8'b11100100 : (m_f == 0 ? 8'b11101000 : 8'b11100010);
        e = pat[7-hh] ^ m_inv; tag = "R3";
      end else if (hh % 2 == 0) begin
        e = ~m_lvl; tag = "R2";
      end else begin
        e = m_lvl ^ m_sub[ch][sl];
        if (sl < 28) tag = (force_zero && valid) ? "R9" : (res24 ? "R4" : "R4/R10");
        else if (sl < 30) tag = "R5";
        else if (sl == 30) tag = (m_f >= 24 && m_f < 28) ? "R8" : "R7";
        else tag = "R6";
      end
      m_lvl = e;
      m_h++;
      if (m_h == 128) begin m_h = 0; m_f = (m_f + 1) % NF; end
    end
    @(negedge clk);
    vectors++;
    if (line !== e) begin
      miscompares++;
      $display("FAIL %s frame %0d half %0d: line_o=%b expected %b", tag, m_f, m_h, line, e);
    end
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic write_sel(int v);
    sel = 3'(v); sel_wr = 1'b1;
    cycle();
    sel_wr = 1'b0; m_sel = v;
  endtask

  bit done = 0;
  initial begin
    #5_000_000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < NS; s++) begin src_l[s] = '0; src_r[s] = '0; end
    for (int b = 0; b < NB; b++) cs_b[b] = 8'(b * 37 + 19);
    cs_b[0][1] = 1'b0;
    cs_b[3][3:0] = 4'h5;  // overwritten by the rate code (R8)
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: idle after reset
    run(8);
    // R3/R7/R10: one full block plus wrap, default source 2, 24-bit, 48 kHz
    rate = 3'd1; vmode = 1; en = 1'b1;
    run(128 * (NF + 2));
    // R1: disable mid-frame, then 16-bit with forced zero (R9, R4)
    en = 1'b0; run(40);
    write_sel(5);
    res24 = 1'b0; force_zero = 1'b1; seed = 1;
    en = 1'b1; run(128 * NF);
    // R9: non-audio set exempts the frame from zeroing
    en = 1'b0; run(4);
    cs_b[0][1] = 1'b1; res24 = 1'b1;
    en = 1'b1; run(128 * 40);
    // R8/R10: every rate code with every source
    force_zero = 1'b0;
    for (int r = 0; r < 8; r++) begin
      en = 1'b0; run(3);
      write_sel((r + 3) % 8);
      rate = 3'(r); seed = r + 2; vmode = r % 2;
      en = 1'b1; run(128 * 30);
    end
    en = 1'b0; run(6);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule